// File: doc/BRIEF.md
# Configuration Frame Readback Sequencer

This block reads one configuration frame back out of the device's internal configuration port. A one-cycle start pulse and a 32-bit frame address start it. It then emits a fixed command script, one 32-bit word at a time, on a valid/ready command stream. The script contains the synchronisation preamble, a CRC reset, the read-configuration command, the frame address and a read-packet header. After the script it emits a long run of no-op words that flush the port's pipeline.

Only after the last script word has been accepted does the block open its capture stream. Through that stream it takes twice the words-per-frame count, because the port returns a pad frame ahead of the requested frame. Each captured word is forwarded in order on a result stream, and the final word carries a last flag. The block then emits a short desynchronise script and raises a one-cycle done pulse. The words-per-frame count and the flush length are parameters.

Top module: `cfg_frame_rdbk_seq`

## Requirements
- R1: After reset, and whenever no readback is running, busy_o, done_o, cmd_valid_o, rd_ready_o and res_valid_o are all low.
- R2: A command word is consumed only on a cycle where cmd_valid_o and cmd_ready_i are both high. While cmd_valid_o is high and cmd_ready_i is low, cmd_valid_o stays high and cmd_data_o does not change.
- R3: Command words 0 to 5 are 0xFFFFFFFF, 0x000000BB, 0x11220044, 0xFFFFFFFF, 0xAA995566 and 0x20000000 (no-op).
- R4: Words 6 to 13 are 0x30008001, then 0x00000007, then six no-ops. 0x30008001 is a type-1 write header with bits [31:29]=001, opcode [28:27]=10, register address [17:13]=4 (command register) and count [10:0]=1.
- R5: Words 14 to 18 are 0x30008001, 0x00000004, a no-op, 0x30002001 (a one-word write header to register address 1), and then the frame address latched at start.
- R6: Words 19 and 20 are 0x28006000 and 0x48000000 ORed with 2×WORDS_PER_FRAME. The first is a type-1 read header, opcode 01, to register address 3. The second is 0x480000CA by default.
- R7: Words 21 to 22+FLUSH_NOOPS (34 no-ops by default) are no-ops. rd_ready_o stays low until all 55 script words have been accepted.
- R8: Exactly 2×WORDS_PER_FRAME words (202 by default) are accepted on the capture stream. They come out on the result stream in arrival order. res_last_o is high on the final word only. While the result stream is stalled, its word is held stable.
- R9: After the final word has been captured, four more command words follow: 0x30008001, 0x0000000D, a no-op and a no-op. Then done_o is high for exactly one cycle, with busy_o already low.
- R10: A start pulse that arrives while busy_o is high is ignored. The running script is not restarted, its frame address is not replaced, and only one done pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| frame_addr_i | input | 32 | Frame address, latched with start |
| busy_o | output | 1 | Readback in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cmd_valid_o | output | 1 | Command word valid |
| cmd_ready_i | input | 1 | Configuration port accepts a command word |
| cmd_data_o | output | 32 | Command word |
| rd_valid_i | input | 1 | Returned word valid |
| rd_ready_o | output | 1 | Block accepts a returned word |
| rd_data_i | input | 32 | Returned word |
| res_valid_o | output | 1 | Result word valid |
| res_ready_i | input | 1 | Consumer accepts a result word |
| res_data_o | output | 32 | Result word |
| res_last_o | output | 1 | Final word of the frame |

## Verification
Some rules can be checked on every cycle, and assertions cover those. Both streams hold their words stable under stall, and capture never overlaps an outstanding command word. The last flag sits on word 202 of the result stream, done is a single pulse while idle, and nothing is asserted when idle. The exact content and order of the 59 command words, the latched frame address, and the in-order forwarding of the captured data can only be shown by the bench's scenarios. The same holds for ignoring a second start. The bench runs these under full-rate and randomly stalled streams.

// File: rtl/cfg_rdbk_pkg.sv
package cfg_rdbk_pkg;

  localparam logic [31:0] W_DUMMY = 32'hFFFF_FFFF;
  localparam logic [31:0] W_BUSW  = 32'h0000_00BB;
  localparam logic [31:0] W_BUSD  = 32'h1122_0044;
  localparam logic [31:0] W_SYNC  = 32'hAA99_5566;
  localparam logic [31:0] W_NOOP  = 32'h2000_0000;

  localparam logic [1:0] OP_RD = 2'b01;
  localparam logic [1:0] OP_WR = 2'b10;

  localparam logic [4:0] RA_FAR  = 5'd1;
  localparam logic [4:0] RA_FDRO = 5'd3;
  localparam logic [4:0] RA_CMD  = 5'd4;

  localparam logic [31:0] CV_RCFG   = 32'd4;
  localparam logic [31:0] CV_RCRC   = 32'd7;
  localparam logic [31:0] CV_DESYNC = 32'd13;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_CAP, ST_DSY} seq_st_t;
  typedef enum logic {PH_HDR, PH_DSY} phase_t;

  function automatic logic [31:0] t1_hdr(input logic [1:0] op, input logic [4:0] ra,
                                         input logic [10:0] cnt);
    return {3'b001, op, 9'd0, ra, 2'd0, cnt};
  endfunction

endpackage

// File: rtl/cfg_script_gen.sv
module cfg_script_gen
  import cfg_rdbk_pkg::*;
#(
  parameter int WORDS_PER_FRAME = 101,
  parameter int IDX_W           = 6
) (
  input  phase_t            phase_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [31:0]       far_i,
  output logic [31:0]       word_o
);
  localparam int TOTAL = 2 * WORDS_PER_FRAME;
  localparam logic [31:0] RDLEN = 32'h4800_0000 | 32'(TOTAL);

  always_comb begin
    word_o = W_NOOP;
    if (phase_i == PH_DSY) begin
      case (int'(idx_i))
        0:       word_o = t1_hdr(OP_WR, RA_CMD, 11'd1);
        1:       word_o = CV_DESYNC;
        default: word_o = W_NOOP;
      endcase
    end else begin
      case (int'(idx_i))
        0:       word_o = W_DUMMY;
        1:       word_o = W_BUSW;
        2:       word_o = W_BUSD;
        3:       word_o = W_DUMMY;
        4:       word_o = W_SYNC;
        6:       word_o = t1_hdr(OP_WR, RA_CMD, 11'd1);
        7:       word_o = CV_RCRC;
        14:      word_o = t1_hdr(OP_WR, RA_CMD, 11'd1);
        15:      word_o = CV_RCFG;
        17:      word_o = t1_hdr(OP_WR, RA_FAR, 11'd1);
        18:      word_o = far_i;
        19:      word_o = t1_hdr(OP_RD, RA_FDRO, 11'd0);
        20:      word_o = RDLEN;
        default: word_o = W_NOOP;
      endcase
    end
  end
endmodule

// File: rtl/cfg_cmd_emit.sv
module cfg_cmd_emit (
  input  logic        clk,
  input  logic        rst,
  input  logic        load_i,
  input  logic [31:0] word_i,
  input  logic        ready_i,
  output logic        free_o,
  output logic        valid_o,
  output logic [31:0] data_o
);
  assign free_o = !valid_o || ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (free_o) begin
      valid_o <= load_i;
      if (load_i) data_o <= word_i;
    end
  end
endmodule

// File: rtl/cfg_rd_capture.sv
module cfg_rd_capture #(
  parameter int TOTAL = 202
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en_i,
  input  logic        rd_valid_i,
  input  logic [31:0] rd_data_i,
  output logic        rd_ready_o,
  input  logic        res_ready_i,
  output logic        res_valid_o,
  output logic [31:0] res_data_o,
  output logic        res_last_o,
  output logic        cap_done_o
);
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(TOTAL - 1);

  logic [CNT_W-1:0] cnt;
  logic             acc;

  assign rd_ready_o = en_i && (!res_valid_o || res_ready_i);
  assign acc        = rd_valid_i && rd_ready_o;
  assign cap_done_o = acc && (cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      res_valid_o <= 1'b0;
      res_data_o  <= '0;
      res_last_o  <= 1'b0;
    end else begin
      if (res_valid_o && res_ready_i) res_valid_o <= 1'b0;
      if (acc) begin
        res_valid_o <= 1'b1;
        res_data_o  <= rd_data_i;
        res_last_o  <= (cnt == LAST_IDX);
        cnt         <= (cnt == LAST_IDX) ? '0 : cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_frame_rdbk_seq.sv
module cfg_frame_rdbk_seq
  import cfg_rdbk_pkg::*;
#(
  parameter int WORDS_PER_FRAME = 101,
  parameter int FLUSH_NOOPS     = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic [31:0] frame_addr_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        cmd_valid_o,
  input  logic        cmd_ready_i,
  output logic [31:0] cmd_data_o,
  input  logic        rd_valid_i,
  output logic        rd_ready_o,
  input  logic [31:0] rd_data_i,
  output logic        res_valid_o,
  input  logic        res_ready_i,
  output logic [31:0] res_data_o,
  output logic        res_last_o
);
  localparam int TOTAL   = 2 * WORDS_PER_FRAME;
  localparam int HDR_LEN = 23 + FLUSH_NOOPS;
  localparam int DSY_LEN = 4;
  localparam int IDX_W   = $clog2(HDR_LEN + 1);
  localparam logic [IDX_W-1:0] HDR_END = IDX_W'(HDR_LEN);
  localparam logic [IDX_W-1:0] DSY_END = IDX_W'(DSY_LEN);

  seq_st_t          st;
  logic [IDX_W-1:0] idx;
  logic [31:0]      far_q;
  logic [31:0]      word;
  logic             emit_free;
  logic             emit_load;
  logic             cap_done;
  phase_t           phase;

  assign phase  = (st == ST_DSY) ? PH_DSY : PH_HDR;
  assign busy_o = (st != ST_IDLE);
  assign emit_load = emit_free &&
                     (((st == ST_HDR) && (idx < HDR_END)) ||
                      ((st == ST_DSY) && (idx < DSY_END)));

  cfg_script_gen #(
    .WORDS_PER_FRAME(WORDS_PER_FRAME),
    .IDX_W(IDX_W)
  ) u_gen (
    .phase_i(phase),
    .idx_i  (idx),
    .far_i  (far_q),
    .word_o (word)
  );

  cfg_cmd_emit u_emit (
    .clk    (clk),
    .rst    (rst),
    .load_i (emit_load),
    .word_i (word),
    .ready_i(cmd_ready_i),
    .free_o (emit_free),
    .valid_o(cmd_valid_o),
    .data_o (cmd_data_o)
  );

  cfg_rd_capture #(
    .TOTAL(TOTAL)
  ) u_cap (
    .clk        (clk),
    .rst        (rst),
    .en_i       (st == ST_CAP),
    .rd_valid_i (rd_valid_i),
    .rd_data_i  (rd_data_i),
    .rd_ready_o (rd_ready_o),
    .res_ready_i(res_ready_i),
    .res_valid_o(res_valid_o),
    .res_data_o (res_data_o),
    .res_last_o (res_last_o),
    .cap_done_o (cap_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      idx    <= '0;
      far_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        ST_IDLE: if (start_i) begin
          far_q <= frame_addr_i;
          idx   <= '0;
          st    <= ST_HDR;
        end
        ST_HDR: if (emit_free) begin
          if (idx < HDR_END) idx <= idx + 1'b1;
          else               st  <= ST_CAP;
        end
        ST_CAP: if (cap_done) begin
          idx <= '0;
          st  <= ST_DSY;
        end
        ST_DSY: if (emit_free) begin
          if (idx < DSY_END) idx <= idx + 1'b1;
          else begin
            st     <= ST_IDLE;
            done_o <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_frame_rdbk_chk.sv
module cfg_frame_rdbk_chk #(
  parameter int WORDS_PER_FRAME = 101
) (
  input logic        clk,
  input logic        rst,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        cmd_valid_o,
  input logic        cmd_ready_i,
  input logic [31:0] cmd_data_o,
  input logic        rd_ready_o,
  input logic        res_valid_o,
  input logic        res_ready_i,
  input logic [31:0] res_data_o,
  input logic        res_last_o
);
  localparam int TOTAL = 2 * WORDS_PER_FRAME;
  localparam int CW    = $clog2(TOTAL + 1);

  logic [CW-1:0] res_cnt;
  always_ff @(posedge clk) begin
    if (rst) res_cnt <= '0;
    else if (res_valid_o && res_ready_i)
      res_cnt <= (res_cnt == CW'(TOTAL - 1)) ? '0 : res_cnt + 1'b1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!cmd_valid_o && !rd_ready_o)); // R1
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_data_o))); // R2
  AST_NO_CAP_WITH_CMD: assert property (@(posedge clk) disable iff (rst)
    rd_ready_o |-> !cmd_valid_o); // R7
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o) && $stable(res_last_o))); // R8
  AST_LAST_POS: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |-> (res_last_o == (res_cnt == CW'(TOTAL - 1)))); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && !cmd_valid_o && !rd_ready_o)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start_i && busy_o) |=> (busy_o || done_o)); // R10
endmodule

bind cfg_frame_rdbk_seq cfg_frame_rdbk_chk #(
  .WORDS_PER_FRAME(WORDS_PER_FRAME)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .cmd_valid_o(cmd_valid_o),
  .cmd_ready_i(cmd_ready_i),
  .cmd_data_o (cmd_data_o),
  .rd_ready_o (rd_ready_o),
  .res_valid_o(res_valid_o),
  .res_ready_i(res_ready_i),
  .res_data_o (res_data_o),
  .res_last_o (res_last_o)
);

// File: tb/sim_cfg_frame_rdbk_seq.sv
`timescale 1ns/1ps
module sim_cfg_frame_rdbk_seq;
  localparam int WPF   = 101;
  localparam int TOTAL = 2 * WPF;
  localparam int HDR   = 55;
  localparam int NCMD  = HDR + 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [31:0] frame_addr_i = '0;
  logic busy_o, done_o, cmd_valid_o, rd_ready_o, res_valid_o, res_last_o;
  logic cmd_ready_i = 1'b0, rd_valid_i = 1'b0, res_ready_i = 1'b0;
  logic [31:0] cmd_data_o, rd_data_i, res_data_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  cfg_frame_rdbk_seq #(.WORDS_PER_FRAME(WPF), .FLUSH_NOOPS(32)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .frame_addr_i(frame_addr_i),
    .busy_o(busy_o), .done_o(done_o),
    .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i), .cmd_data_o(cmd_data_o),
    .rd_valid_i(rd_valid_i), .rd_ready_o(rd_ready_o), .rd_data_i(rd_data_i),
    .res_valid_o(res_valid_o), .res_ready_i(res_ready_i),
    .res_data_o(res_data_o), .res_last_o(res_last_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_cmd(input int i, input logic [31:0] a);
    case (i)
      0, 3:    return 32'hFFFF_FFFF;             // R3
      1:       return 32'h0000_00BB;             // R3
      2:       return 32'h1122_0044;             // R3
      4:       return 32'hAA99_5566;             // R3
      6, 14:   return 32'h3000_8001;             // R4 R5
      7:       return 32'h0000_0007;             // R4
      15:      return 32'h0000_0004;             // R5
      17:      return 32'h3000_2001;             // R5
      18:      return a;                         // R5
      19:      return 32'h2800_6000;             // R6
      20:      return 32'h4800_0000 | TOTAL;     // R6
      HDR:     return 32'h3000_8001;             // R9
      HDR + 1: return 32'h0000_000D;             // R9
      default: return 32'h2000_0000;
    endcase
  endfunction

  function automatic string req_of(input int i);
    if (i < 6)   return "R3";
    if (i < 14)  return "R4";
    if (i < 19)  return "R5";
    if (i < 21)  return "R6";
    if (i < HDR) return "R7";
    return "R9";
  endfunction

  function automatic logic [31:0] rd_pat(input logic [31:0] a, input int k);
    return 32'hC0DE_0000 ^ (32'(k) * 32'h9E37_79B1) ^ a;
  endfunction

  task automatic run_frame(input logic [31:0] addr, input int pc, input int pr,
                           input int ps, input bit inj);
    int ncmd = 0, nrd = 0, nres = 0, ndone = 0, cyc = 0;
    bit fin = 0, prev_stall = 0;
    logic [31:0] prev_data = '0;
    @(negedge clk);
    start_i = 1'b1;
    frame_addr_i = addr;
    @(negedge clk);
    start_i = 1'b0;
    while (!fin && cyc < 8000) begin
      cmd_ready_i  = (($urandom % 100) < pc);
      rd_valid_i   = (($urandom % 100) < pr);
      rd_data_i    = rd_pat(addr, nrd);
      res_ready_i  = (($urandom % 100) < ps);
      start_i      = inj && busy_o && (($urandom % 8) == 0);
      frame_addr_i = ~addr;
      #1;
      if (prev_stall)
        chk(cmd_valid_o && cmd_data_o == prev_data, "R2 stall hold", cmd_data_o, prev_data);
      if (cmd_valid_o && cmd_ready_i) begin
        chk(ncmd < NCMD && cmd_data_o == exp_cmd(ncmd, addr), req_of(ncmd),
            cmd_data_o, exp_cmd(ncmd, addr));
        if (ncmd >= HDR) chk(nrd == TOTAL, "R9 desync after capture", nrd, TOTAL);
        ncmd++;
      end
      prev_stall = cmd_valid_o && !cmd_ready_i;
      prev_data  = cmd_data_o;
      if (rd_valid_i && rd_ready_o) begin
        chk(ncmd == HDR, "R7 capture after flush", ncmd, HDR);
        nrd++;
      end
      if (res_valid_o && res_ready_i) begin
        chk(res_data_o == rd_pat(addr, nres), "R8 result data", res_data_o, rd_pat(addr, nres));
        chk(res_last_o == (nres == TOTAL - 1), "R8 last flag", res_last_o, (nres == TOTAL - 1));
        nres++;
      end
      if (done_o) begin
        ndone++;
        chk(!busy_o && ncmd == NCMD && nrd == TOTAL, "R9 done", ncmd, NCMD);
      end
      fin = (ndone > 0) && (!res_valid_o || res_ready_i);
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    cmd_ready_i = 1'b0;
    rd_valid_i = 1'b0;
    res_ready_i = 1'b0;
    chk(cyc < 8000, "R9 watchdog frame", cyc, 8000);
    chk(nres == TOTAL, "R8 result count", nres, TOTAL);
    chk(ndone == 1, "R10 single done", ndone, 1);
    repeat (5) @(negedge clk);
    chk(!busy_o && !cmd_valid_o && !rd_ready_o && !res_valid_o, "R10 no restart",
        {busy_o, cmd_valid_o, rd_ready_o, res_valid_o}, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rd_valid_i = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!busy_o && !done_o && !cmd_valid_o && !rd_ready_o && !res_valid_o, "R1 in reset",
        {busy_o, done_o, cmd_valid_o, rd_ready_o, res_valid_o}, 0);
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!busy_o && !done_o && !cmd_valid_o && !rd_ready_o && !res_valid_o, "R1 idle",
        {busy_o, done_o, cmd_valid_o, rd_ready_o, res_valid_o}, 0);
    rd_valid_i = 1'b0;
    run_frame(32'h0040_0100, 100, 100, 100, 1'b0);   // directed full rate
    run_frame(32'h0000_0000, 20, 90, 90, 1'b0);      // heavy command stall
    run_frame(32'hFFFF_FFFF, 90, 60, 10, 1'b0);      // heavy result stall
    run_frame(32'h0123_4567, 60, 60, 60, 1'b1);      // R10 start while busy
    for (int f = 0; f < 4; f++)
      run_frame($urandom, 30 + ($urandom % 70), 30 + ($urandom % 70),
                30 + ($urandom % 70), f[0]);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule